// File: doc/BRIEF.md
# Grouped Prescale and Divide Tick Generator

This block turns one fast clock into five per-channel tick enables for a multi-channel PWM timer. Two 8-bit prescalers each serve a fixed group of channels. Channels 0 and 1 share the first prescaler. Channels 2, 3 and 4 share the second. Behind its group prescaler, each channel picks a power-of-two divider through a 4-bit select field. A select code can instead route a synchronised external clock input to the channel. Each tick is a one-cycle enable, meant to step a channel counter that lives outside this block.

Configuration arrives through a simple write port with two word addresses. Address 0 holds the two prescale values. Address 1 holds the five select fields. When a write changes a group's prescale value, that group restarts in phase. Its prescale counter and the divider counters of its channels all return to zero, so the first tick after the write arrives exactly one full tick period later.

Top module: `pwm_tick_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every tick output is 0. Reset leaves every prescale value at 0 and every select code at 0, so each channel then ticks once every 2 cycles.
- R2: Word address 0 holds two prescale values P. Bits [7:0] set P for group A (channels 0 and 1). Bits [15:8] set P for group B (channels 2 to 4). A group's prescaled pulse rate is the clock rate divided by P+1.
- R3: Word address 1 holds one 4-bit select field per channel, at bits [4c+3:4c] for channel c. A select code k in the range 0 to 3 divides the group's prescaled pulse by 2^(k+1).
- R4: In divider mode, a channel ticks as a one-cycle pulse once every (P+1)·2^(k+1) clock cycles, and only in the cycle after its group's prescaler pulsed.
- R5: Select codes 5 to 15 divide the prescaled pulse by 16, which is the largest divider.
- R6: Select code 4 routes an external clock to the channel instead of the divider. Channels 0 and 1 follow external input bit 0. Channels 2 to 4 follow external input bit 1. A channel in this mode ignores the other external bit.
- R7: Each rising edge of an external clock input gives exactly one tick pulse, one cycle wide. The pulse appears on the output after the third rising clock edge that samples the input high. Holding the input high gives no further pulses.
- R8: A write to address 0 that changes a group's prescale value restarts that group. The first divider-mode tick then appears exactly (P+1)·2^(k+1) clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | Word select: 0 = prescale values, 1 = select fields |
| cfgWdata | input | 20 | Configuration write data |
| extClk | input | 2 | External clock inputs, bit 0 for group A, bit 1 for group B |
| tick | output | 5 | Per-channel one-cycle tick enables |

## Verification
A divider-mode tick is registered. Its first pulse is due exactly (P+1)·2^(k+1) edges after the edge that commits the prescale write, and the same count separates every later pulse. An external-clock pulse is due after the third clock edge that samples the raised input: two synchroniser stages, then the output register. Each test drives inputs at the falling edge, counts rising edges from the commit edge, and samples one time unit after each edge. Pulse positions are therefore compared against exact edge counts, not windows. A stale tick left over from the old setting is visible only at the commit edge itself, and that edge is never sampled.

// File: rtl/tickgen_pkg.sv
package tickgen_pkg;
  localparam int NUM_CH   = 5;
  localparam int NUM_GRP  = 2;
  localparam int GRP0_CH  = 2;   // channels below this index use group A
  localparam int PRE_W    = 8;
  localparam int MUX_W    = 4;
  localparam int DATA_W   = NUM_CH * MUX_W;
  localparam int MAX_LOG2 = 4;   // largest divider is 2**MAX_LOG2
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);
  localparam int SYNC_W   = 3;   // two sync flops plus one edge history flop

  // strobes from the control to the datapath
  typedef struct packed {
    logic [NUM_GRP-1:0] grpRestart;
    logic [NUM_CH-1:0]  chRestart;
  } strobe_t;
endpackage

// File: rtl/tickgen_ctrl.sv
module tickgen_ctrl
  import tickgen_pkg::*;
#(
  parameter int          DIV_BASE = 1,
  parameter logic [15:0] EXT_MASK = 16'h0010
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic                            cfgAddr,
  input  logic [DATA_W-1:0]               cfgWdata,
  output logic [NUM_GRP-1:0][PRE_W-1:0]   preVal,
  output logic [NUM_CH-1:0]               extSel,
  output logic [NUM_CH-1:0][LOG_W-1:0]    divLog,
  output strobe_t                         strb
);
  logic [NUM_GRP-1:0][PRE_W-1:0] preReg;
  logic [NUM_CH-1:0][MUX_W-1:0]  selReg;
  logic                          wrPre;
  logic                          wrSel;

  assign wrPre = cfgWe && !cfgAddr;
  assign wrSel = cfgWe && cfgAddr;

  // a group restarts only when its prescale value really changes
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      strb.grpRestart[g] = wrPre && (cfgWdata[g*PRE_W +: PRE_W] != preReg[g]);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      strb.chRestart[c] = wrSel && (cfgWdata[c*MUX_W +: MUX_W] != selReg[c]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preReg <= '0;
      selReg <= '0;
    end else begin
      if (wrPre) begin
        for (int g = 0; g < NUM_GRP; g++) preReg[g] <= cfgWdata[g*PRE_W +: PRE_W];
      end
      if (wrSel) begin
        for (int c = 0; c < NUM_CH; c++) selReg[c] <= cfgWdata[c*MUX_W +: MUX_W];
      end
    end
  end

  assign preVal = preReg;

  // select decode: external code, else log2 divider clamped to the largest
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      int effLog;
      effLog    = int'(selReg[c]) + DIV_BASE;
      extSel[c] = EXT_MASK[selReg[c]];
      if (effLog > MAX_LOG2) divLog[c] = LOG_W'(MAX_LOG2);
      else                   divLog[c] = LOG_W'(effLog);
    end
  end
endmodule

// File: rtl/tickgen_dp.sv
module tickgen_dp
  import tickgen_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_GRP-1:0][PRE_W-1:0]   preVal,
  input  logic [NUM_CH-1:0]               extSel,
  input  logic [NUM_CH-1:0][LOG_W-1:0]    divLog,
  input  strobe_t                         strb,
  input  logic [NUM_GRP-1:0]              extClk,
  output logic [NUM_GRP-1:0][PRE_W-1:0]   preCnt,
  output logic [NUM_GRP-1:0]              preTick,
  output logic [NUM_CH-1:0]               tick
);
  localparam logic [MAX_LOG2-1:0] ONE = MAX_LOG2'(1);

  logic [NUM_GRP-1:0] extPulse;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    logic [SYNC_W-1:0] syncSh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   preCnt[g] <= '0;
      else if (strb.grpRestart[g]) preCnt[g] <= '0;
      else if (preTick[g])         preCnt[g] <= '0;
      else                         preCnt[g] <= preCnt[g] + 1'b1;
    end

    assign preTick[g] = (preCnt[g] == preVal[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncSh <= '0;
      else       syncSh <= {syncSh[SYNC_W-2:0], extClk[g]};
    end

    assign extPulse[g] = syncSh[SYNC_W-2] && !syncSh[SYNC_W-1];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    localparam int G = (c < GRP0_CH) ? 0 : 1;
    logic [MAX_LOG2-1:0] divCnt;
    logic [MAX_LOG2-1:0] divMask;
    logic                divHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      divCnt <= '0;
      else if (strb.grpRestart[G] || strb.chRestart[c]) divCnt <= '0;
      else if (preTick[G])                            divCnt <= divCnt + 1'b1;
    end

    assign divMask = (ONE << divLog[c]) - ONE;
    assign divHit  = preTick[G] && ((divCnt & divMask) == divMask);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tick[c] <= 1'b0;
      else       tick[c] <= extSel[c] ? extPulse[G] : divHit;
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import tickgen_pkg::*;
#(
  parameter int          DIV_BASE = 1,
  parameter logic [15:0] EXT_MASK = 16'h0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic               cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [NUM_GRP-1:0] extClk,
  output logic [NUM_CH-1:0]  tick
);
  logic [NUM_GRP-1:0][PRE_W-1:0] preVal;
  logic [NUM_GRP-1:0][PRE_W-1:0] preCnt;
  logic [NUM_GRP-1:0]            preTick;
  logic [NUM_CH-1:0]             extSel;
  logic [NUM_CH-1:0][LOG_W-1:0]  divLog;
  strobe_t                       strb;

  tickgen_ctrl #(.DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .preVal(preVal), .extSel(extSel),
    .divLog(divLog), .strb(strb)
  );

  tickgen_dp dp_i (
    .clk(clk), .rstN(rstN), .preVal(preVal), .extSel(extSel),
    .divLog(divLog), .strb(strb), .extClk(extClk), .preCnt(preCnt),
    .preTick(preTick), .tick(tick)
  );
endmodule

// File: rtl/tickgen_chk.sv
module tickgen_chk
  import tickgen_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgWe,
  input logic                          cfgAddr,
  input logic [DATA_W-1:0]             cfgWdata,
  input logic [NUM_GRP-1:0][PRE_W-1:0] preVal,
  input logic [NUM_GRP-1:0][PRE_W-1:0] preCnt,
  input logic [NUM_GRP-1:0]            preTick,
  input logic [NUM_CH-1:0]             extSel,
  input logic [NUM_CH-1:0]             tick
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> tick == '0);

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrpChk
    // R2
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      preCnt[g] <= preVal[g]);
    // R8
    pre_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && !cfgAddr && cfgWdata[g*PRE_W +: PRE_W] != preVal[g]) |=> preCnt[g] == '0);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gChChk
    localparam int G = (c < GRP0_CH) ? 0 : 1;
    // R4
    div_after_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tick[c] && !$past(extSel[c])) |-> $past(preTick[G]));
    // R7
    ext_single_chk: assert property (@(posedge clk) disable iff (!rstN)
      (tick[c] && $past(extSel[c]) && extSel[c]) |=> !tick[c]);
  end
endmodule

bind pwm_tick_gen tickgen_chk chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .cfgWdata(cfgWdata), .preVal(preVal), .preCnt(preCnt),
  .preTick(preTick), .extSel(extSel), .tick(tick)
);

// File: tb/pwm_tick_gen_tb_top.sv
module pwm_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgAddr = 1'b0;
  logic [19:0] cfgWdata = '0;
  logic [1:0]  extClk = '0;
  logic [4:0]  tick;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  pwm_tick_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .extClk(extClk), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write ends just after the commit edge
  task automatic writeCfg(input logic addr, input logic [19:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = data;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  // counts edges from the commit edge; first pulse and spacing
  task automatic measure(input int ch, input int expFirst, input int expPeriod,
                         input string req);
    int first = -1;
    int second = -1;
    for (int n = 1; n <= 400 && second < 0; n++) begin
      @(posedge clk); #1;
      if (tick[ch]) begin
        if (first < 0) first = n;
        else second = n;
      end
    end
    if (expFirst >= 0) check({req, " first tick"}, first, expFirst);
    check({req, " tick period"}, second - first, expPeriod);
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R1 tick in reset", int'(tick), 0);
    end
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 tick after release", int'(tick), 0);
    measure(0, -1, 2, "R1 default ch0");
    measure(4, -1, 2, "R1 default ch4");
  endtask

  task automatic testDivide();
    // select codes: ch0=0 ch1=2 ch2=1 ch3=3 ch4=0
    writeCfg(1'b1, 20'h03120);
    writeCfg(1'b0, 20'h00002);
    measure(0, 6, 6, "R2 R3 R8 ch0 P=2 /2");
    writeCfg(1'b0, 20'h00003);
    measure(1, 32, 32, "R3 R4 R8 ch1 P=3 /8");
    writeCfg(1'b0, 20'h00403);
    measure(4, 10, 10, "R2 R8 ch4 P=4 /2");
    writeCfg(1'b0, 20'h00103);
    measure(3, 32, 32, "R3 R8 ch3 P=1 /16");
    writeCfg(1'b0, 20'h00203);
    measure(2, 12, 12, "R3 R8 ch2 P=2 /4");
  endtask

  task automatic testClamp();
    writeCfg(1'b1, 20'h03190);
    writeCfg(1'b0, 20'h00200);
    measure(1, 16, 16, "R5 ch1 code 9");
    writeCfg(1'b1, 20'h031F0);
    writeCfg(1'b0, 20'h00201);
    measure(1, 32, 32, "R5 ch1 code 15");
  endtask

  task automatic extEdge(input int g, input int chOn, input int chOff);
    int offHits = 0;
    @(negedge clk); extClk[g] = 1'b1;
    for (int e = 1; e <= 10; e++) begin
      @(posedge clk); #1;
      if (tick[chOff]) offHits++;
      if (e == 2) check("R7 no tick at edge 2", int'(tick[chOn]), 0);
      else if (e == 3) check("R7 tick at edge 3", int'(tick[chOn]), 1);
      else if (e >= 4) check("R7 held high no pulse", int'(tick[chOn]), 0);
    end
    check("R6 other group input ignored", offHits, 0);
    @(negedge clk); extClk[g] = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic testExternal();
    // ch0=4 ch1=F ch2=4 ch3=3 ch4=0
    writeCfg(1'b1, 20'h034F4);
    repeat (4) @(posedge clk);
    extEdge(0, 0, 2);
    extEdge(1, 2, 0);
    extEdge(0, 0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testDivide();
    testClamp();
    testExternal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule